// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Slave

This block is the device end of a one-wire control bus. The wire is open-drain and active low. The host encodes every symbol as the width of one low pulse: a short pulse is a zero, a medium pulse is a one, and a long pulse is a frame marker. The slave times each low pulse against a microsecond tick derived from its own clock. It assembles the symbols into frames and keeps a parallel control word that steers the surrounding analog logic.

Every frame opens with a marker and a three-bit opcode, and it closes with a marker followed by three ones. The opcodes are address select, write, broadcast and read. The device identity comes from a four-bit strap. A write needs a prior matching address frame, while a broadcast reaches every device on the bus. A write or broadcast takes effect only when its frame closes. A word of all ones restores the power-up defaults instead of being stored.

During a read frame, each short host pulse is a prompt. The slave answers it by holding the wire low, or leaving it released, inside a fixed window that follows the prompt's falling edge. The bits come out least significant first and wrap around after the last one.

Top module: `swp_slave`

## Requirements
- R1: After reset, `ctrl_o` equals the parameter `REG_INIT` (0x0C0C0C by default) and `line_pd_o` is 0.
- R2: A low pulse is classified from its measured length in microsecond ticks: 1 to 8 ticks is a zero (or a prompt), 24 to 36 ticks is a one, and 80 to 120 ticks is a marker.
- R3: A frame is a marker, then three opcode bits in transmission order (first bit leftmost), then a body. It is closed by a marker followed by the bits 1,1,1. The opcodes are 010 address select, 001 write, 000 broadcast and 101 read. `ctrl_o` changes only at the closing bits, never while the body is arriving.
- R4: An address frame carries 4 identity bits, least significant first. When they equal `dev_id_i`, the device is selected for the write and read frames that follow. When they differ, the device is deselected and ignores write and read frames.
- R5: A write is stored only if at least `REG_W` (24) data bits arrived, least significant first. When more arrive, the last `REG_W` bits are kept. Fewer bits leave `ctrl_o` unchanged.
- R6: A broadcast frame loads the data without any prior address frame, under the same bit-count rule as R5.
- R7: A written or broadcast word of all ones loads `REG_INIT` and is never itself stored.
- R8: In a read frame of a selected device, each prompt returns the next register bit, least significant first, and wraps to bit 0 after `REG_W` prompts. A 1 bit is returned as a pull-down from 2 to 5 ticks after the prompt's falling edge is seen. A 0 bit leaves the line released.
- R9: A low pulse whose length falls outside all three ranges aborts the current frame. Nothing is committed, and decoding resumes at the next marker.
- R10: `line_pd_o` is 0 at all times except inside a read window of a selected read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_PER_US` cycles per microsecond |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the bus wire |
| line_pd_o | output | 1 | Pull-down enable for the open-drain wire driver |
| dev_id_i | input | 4 | Strapped device identity |
| ctrl_o | output | REG_W | Control register contents |

## Verification
During a read, the slave measures a pulse and drives the same wire at the same moment. A prompt's falling edge both starts a width measurement and opens the answer window in which the slave's own pull-down keeps the wire low. The bench provokes this by releasing the wire one microsecond into each prompt, so that every 1 bit produces a second low stretch caused by the slave itself. It then judges that the returned bit is right at four microseconds, that the wire is free again at seven, and that the next prompt still counts as a prompt rather than a framing error. The closing marker of the read frame also starts with a drive window, and the bench checks that the frame still closes cleanly and that no pull-down leaks outside selected read frames.

// File: rtl/swp_slave.sv
module swp_slave #(
  parameter int REG_W      = 24,
  parameter int CLK_PER_US = 50,
  parameter logic [REG_W-1:0] REG_INIT = 'h0C0C0C,
  parameter int Z_MIN = 1,
  parameter int Z_MAX = 8,
  parameter int O_MIN = 24,
  parameter int O_MAX = 36,
  parameter int M_MIN = 80,
  parameter int M_MAX = 120,
  parameter int RD_ON  = 2,
  parameter int RD_OFF = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic             line_pd_o,
  input  logic [3:0]       dev_id_i,
  output logic [REG_W-1:0] ctrl_o
);
  localparam int CW = $clog2(M_MAX + 2);
  localparam int PW = $clog2(CLK_PER_US);
  localparam int NW = $clog2(REG_W + 1);
  localparam int IW = $clog2(REG_W);
  localparam logic [PW-1:0] PRE_TOP = PW'(CLK_PER_US - 1);
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] ZLO = CW'(Z_MIN), ZHI = CW'(Z_MAX);
  localparam logic [CW-1:0] OLO = CW'(O_MIN), OHI = CW'(O_MAX);
  localparam logic [CW-1:0] MLO = CW'(M_MIN), MHI = CW'(M_MAX);
  localparam logic [CW-1:0] WON = CW'(RD_ON), WOFF = CW'(RD_OFF);
  localparam logic [NW-1:0] NFULL = NW'(REG_W);
  localparam logic [IW-1:0] ILAST = IW'(REG_W - 1);

  localparam logic [1:0] ST_IDLE = 2'd0, ST_OPC = 2'd1, ST_BODY = 2'd2;
  localparam logic [2:0] P_NONE = 3'd0, P_ADDR = 3'd1, P_WR = 3'd2, P_BC = 3'd3, P_RD = 3'd4;
  localparam logic [1:0] SY_Z = 2'd0, SY_O = 2'd1, SY_M = 2'd2, SY_E = 2'd3;

  logic [1:0]       sync;
  logic             low_act, hold, rbit, sel;
  logic [PW-1:0]    pre;
  logic [CW-1:0]    cnt;
  logic [1:0]       st, obits, sym;
  logic [2:0]       pend, opc;
  logic [REG_W-1:0] sh;
  logic [NW-1:0]    nb;
  logic [IW-1:0]    rptr;

  wire line_s  = sync[1];
  wire in_slot = hold && (cnt < WOFF);
  wire fall    = !low_act && !line_s;
  wire p_end   = low_act && line_s && !in_slot;
  wire b       = (sym == SY_O);
  wire [2:0] op3 = {opc[1:0], b};

  assign line_pd_o = in_slot && rbit && (cnt >= WON);

  always_comb begin
    if (cnt >= ZLO && cnt <= ZHI)      sym = SY_Z;
    else if (cnt >= OLO && cnt <= OHI) sym = SY_O;
    else if (cnt >= MLO && cnt <= MHI) sym = SY_M;
    else                               sym = SY_E;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; low_act <= 1'b0; hold <= 1'b0; rbit <= 1'b0;
      pre <= '0; cnt <= '0;
    end else begin
      sync <= {sync[0], line_i};
      if (fall) begin
        low_act <= 1'b1;
        hold    <= (st == ST_BODY) && (pend == P_RD);
        rbit    <= ctrl_o[rptr];
        pre     <= PW'(1);
        cnt     <= '0;
      end else if (p_end) begin
        low_act <= 1'b0;
        hold    <= 1'b0;
      end else if (low_act) begin
        pre <= (pre == PRE_TOP) ? '0 : pre + 1'b1;
        if (pre == PRE_TOP && cnt != CMAX) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; pend <= P_NONE; obits <= '0; opc <= '0;
      sh <= '0; nb <= '0; rptr <= '0; sel <= 1'b0; ctrl_o <= REG_INIT;
    end else if (p_end) begin
      if (sym == SY_E) begin
        st <= ST_IDLE; pend <= P_NONE;
      end else if (sym == SY_M) begin
        st <= ST_OPC; obits <= '0;
      end else begin
        case (st)
          ST_OPC: begin
            if (obits != 2'd2) begin
              opc <= op3; obits <= obits + 1'b1;
            end else begin
              st <= ST_BODY; nb <= '0; rptr <= '0;
              case (op3)
                3'b111: begin
                  st <= ST_IDLE; pend <= P_NONE;
                  if (pend == P_ADDR)
                    sel <= (nb >= NW'(4)) && (sh[REG_W-1 -: 4] == dev_id_i);
                  if ((pend == P_WR || pend == P_BC) && nb == NFULL)
                    ctrl_o <= (&sh) ? REG_INIT : sh;
                end
                3'b010:  pend <= P_ADDR;
                3'b001:  pend <= sel ? P_WR : P_NONE;
                3'b000:  pend <= P_BC;
                3'b101:  pend <= sel ? P_RD : P_NONE;
                default: begin st <= ST_IDLE; pend <= P_NONE; end
              endcase
            end
          end
          ST_BODY: begin
            sh <= {b, sh[REG_W-1:1]};
            if (nb != NFULL) nb <= nb + 1'b1;
            if (pend == P_RD && !b) rptr <= (rptr == ILAST) ? '0 : rptr + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/swp_slave_chk.sv
module swp_slave_chk #(
  parameter int REG_W      = 24,
  parameter int CLK_PER_US = 50,
  parameter int RD_ON      = 2,
  parameter int RD_OFF     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_pd_o,
  input logic [REG_W-1:0] ctrl_o,
  input logic [1:0]       st,
  input logic [2:0]       pend
);
  localparam int LIM = (RD_OFF - RD_ON) * CLK_PER_US;
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else        run <= line_pd_o ? run + 1 : '0;

  p_pd_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_pd_o |-> (st == 2'd2 && pend == 3'd4));

  p_never_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ctrl_o));

  p_commit_at_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $past(st == 2'd1));

  p_pd_window_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_pd_o |-> (run < LIM));
endmodule

bind swp_slave swp_slave_chk #(
  .REG_W(REG_W), .CLK_PER_US(CLK_PER_US), .RD_ON(RD_ON), .RD_OFF(RD_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_pd_o(line_pd_o), .ctrl_o(ctrl_o),
  .st(st), .pend(pend)
);

// File: tb/swp_slave_test.sv
module swp_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int US = 4;
  localparam logic [23:0] INIT = 24'h0C0C0C;
  localparam logic [3:0] MY_ID = 4'hA;
  localparam logic [3:0] OTHER_ID = 4'h5;

  // {kind[1:0], nbits[5:0], data[27:0], expect[23:0]}; kind 0 broadcast, 1 addr match + write, 2 addr mismatch + write
  localparam logic [59:0] VEC [8] = '{
    {2'd0, 6'd24, 28'h0123456, 24'h123456},
    {2'd1, 6'd24, 28'h0ABCDEF, 24'hABCDEF},
    {2'd2, 6'd24, 28'h0111111, 24'hABCDEF},
    {2'd1, 6'd20, 28'h0055555, 24'hABCDEF},
    {2'd1, 6'd28, 28'hF654321, 24'hF65432},
    {2'd0, 6'd24, 28'h0FFFFFF, 24'h0C0C0C},
    {2'd0, 6'd24, 28'h0000001, 24'h000001},
    {2'd1, 6'd24, 28'h0800000, 24'h800000}
  };

  logic clk = 1'b0, rst_n = 1'b0, host_low = 1'b0;
  logic line_pd;
  logic [23:0] ctrl;
  int checks = 0, fails = 0, pd_bad = 0;
  bit rd_ok = 1'b0, done = 1'b0;

  wire line = ~(host_low | line_pd);

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_slave #(.CLK_PER_US(US)) uut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .line_pd_o(line_pd),
    .dev_id_i(MY_ID), .ctrl_o(ctrl)
  );

  always @(negedge clk) if (rst_n && line_pd && !rd_ok) pd_bad++;

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic low_for(input int lo_us, input int total_us);
    @(negedge clk) host_low = 1'b1;
    repeat (lo_us * US) @(negedge clk);
    host_low = 1'b0;
    repeat ((total_us - lo_us) * US) @(negedge clk);
  endtask

  task automatic send_bit(input bit v);
    if (v) low_for(30, 33); else low_for(5, 8);
  endtask

  task automatic mark();
    low_for(100, 103);
  endtask

  task automatic open_frame(input logic [2:0] op, input logic [27:0] d, input int n);
    mark();
    send_bit(op[2]); send_bit(op[1]); send_bit(op[0]);
    for (int i = 0; i < n; i++) send_bit(d[i]);
  endtask

  task automatic close_frame();
    mark();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
  endtask

  task automatic address(input logic [3:0] id);
    open_frame(3'b010, {24'd0, id}, 4);
    close_frame();
  endtask

  task automatic prompt(input bit exp_bit, input string tag);
    @(negedge clk) host_low = 1'b1;
    repeat (US) @(negedge clk);
    host_low = 1'b0;
    repeat (3 * US - 1) @(negedge clk);
    check(line_pd == exp_bit && line == !exp_bit, tag, {23'd0, line_pd}, {23'd0, exp_bit});
    repeat (3 * US) @(negedge clk);
    check(line_pd == 1'b0, "R10 released after window", {23'd0, line_pd}, 24'd0);
    repeat (US) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] pat;
    repeat (5) @(negedge clk);
    check(ctrl == INIT, "R1 reset value", ctrl, INIT);
    check(line_pd == 1'b0, "R1 reset pull-down", {23'd0, line_pd}, 24'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R4 R5 R6 R7: table of write and broadcast frames
    for (int v = 0; v < 8; v++) begin
      logic [1:0] kind; logic [5:0] nb; logic [27:0] d; logic [23:0] e;
      {kind, nb, d, e} = VEC[v];
      if (kind == 2'd1) address(MY_ID);
      if (kind == 2'd2) address(OTHER_ID);
      open_frame(kind == 2'd0 ? 3'b000 : 3'b001, d, int'(nb));
      close_frame();
      repeat (4) @(negedge clk);
      check(ctrl == e, $sformatf("R2/R4/R5/R6/R7 vector %0d", v), ctrl, e);
    end

    // R3: body received but not committed until the closing bits
    address(MY_ID);
    open_frame(3'b001, 28'h0135790, 24);
    repeat (4) @(negedge clk);
    check(ctrl == 24'h800000, "R3 no commit before close", ctrl, 24'h800000);
    close_frame();
    repeat (4) @(negedge clk);
    check(ctrl == 24'h135790, "R3 commit at close", ctrl, 24'h135790);

    // R9: out-of-range pulse aborts the frame
    address(MY_ID);
    open_frame(3'b001, 28'h000FF00, 24);
    low_for(15, 18);
    close_frame();
    repeat (4) @(negedge clk);
    check(ctrl == 24'h135790, "R9 aborted frame", ctrl, 24'h135790);

    // R8: read with wrap
    pat = 24'h96A5C3;
    open_frame(3'b000, {4'd0, pat}, 24);
    close_frame();
    repeat (4) @(negedge clk);
    check(ctrl == pat, "R6 broadcast before read", ctrl, pat);
    address(MY_ID);
    rd_ok = 1'b1;
    open_frame(3'b101, 28'd0, 0);
    for (int i = 0; i < 26; i++) prompt(pat[i % 24], $sformatf("R8 read bit %0d", i));
    close_frame();
    rd_ok = 1'b0;
    repeat (4) @(negedge clk);
    check(ctrl == pat, "R8 read leaves register", ctrl, pat);

    // R4: deselected device stays silent on read
    address(OTHER_ID);
    open_frame(3'b101, 28'd0, 0);
    for (int i = 0; i < 4; i++) prompt(1'b0, "R4 unselected read silent");
    close_frame();

    check(pd_bad == 0, "R10 pull-down outside read", pd_bad[23:0], 24'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule